// File: doc/BRIEF.md
# CAN Transmit Mailbox Priority Arbiter

This block holds a set of transmit mailboxes and picks the one that is offered next to a CAN bit engine. Software configures each mailbox through a single write port. It sets a mode and a 4-bit priority, and it loads the identifier, two data words and a control word. A control write with the transfer-command bit set marks the mailbox pending and clears its ready flag.

Among the mailboxes that are in transmit mode and pending, the arbiter picks the smallest priority value. When several share that value, the lowest mailbox index wins. The chosen frame is presented on a request/accept handshake. After acceptance the choice is frozen until the transmitter reports completion or abort. That report returns the mailbox to ready, sets the abort flag if the frame was aborted, and pulses the mailbox's event bit for one cycle.

Top module: `can_tx_arbiter`

## Requirements
- R1: After reset every mailbox is disabled, every ready flag is 1, every abort flag and event bit is 0, and `tx_req` is 0.
- R2: A control write (register code 4) with bit 23 set, to a mailbox in transmit mode (mode field bits 26:24 = 3) whose ready flag is 1, clears the ready flag and makes the mailbox pending. The same write loads the DLC from bits 19:16 and the remote-frame flag from bit 20, and both appear on `tx_dlc` and `tx_rtr` when the mailbox is selected.
- R3: A control write to a mailbox that is not in transmit mode has no effect: its ready flag stays 1 and no request is raised.
- R4: Among the pending transmit-mode mailboxes, the one with the smallest priority value (mode register code 0, bits 19:16) is selected. Value 0 is the highest priority.
- R5: When pending mailboxes share the best priority, the lowest-numbered one is selected.
- R6: An identifier write (register code 1) takes effect only while the mailbox mode is disabled (mode 0). In any other mode the write is ignored.
- R7: Identifier decode: bit 29 of the identifier register drives `tx_ext`. For an extended frame `tx_ident` carries bits 28:0. For a standard frame it carries bits 28:18, right-aligned with upper bits zero.
- R8: Writing a non-transmit mode to a pending mailbox that has not been accepted cancels the request and sets its ready flag to 1.
- R9: From acceptance (`tx_req` and `tx_accept` high at a clock edge) until `tx_done` or `tx_abort`, `tx_req` is 0 and `tx_mb` does not change, even if a better mailbox becomes pending.
- R10: On `tx_done` the in-flight mailbox's ready flag sets, its abort flag is 0, and its event bit pulses high for exactly one cycle.
- R11: On `tx_abort` the in-flight mailbox's ready and abort flags both set and its event bit pulses for one cycle. The abort flag clears on the next accepted control write to that mailbox.
- R12: `tx_data` presents the high data word (register code 3) in bits 63:32 and the low data word (register code 2) in bits 31:0 of the selected mailbox.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mb | input | 4 | Mailbox index for the write |
| cfg_reg | input | 3 | Register code: 0 mode, 1 identifier, 2 data low, 3 data high, 4 control |
| cfg_wdata | input | 32 | Write data |
| tx_req | output | 1 | A selected frame is offered |
| tx_accept | input | 1 | Transmitter takes the offered frame |
| tx_done | input | 1 | In-flight frame completed |
| tx_abort | input | 1 | In-flight frame aborted |
| tx_mb | output | 4 | Index of the offered or in-flight mailbox |
| tx_ext | output | 1 | Extended identifier flag |
| tx_ident | output | 29 | Decoded identifier |
| tx_rtr | output | 1 | Remote frame request |
| tx_dlc | output | 4 | Data length code |
| tx_data | output | 64 | Payload, high word in upper half |
| mb_ready | output | 16 | Per-mailbox ready flags |
| mb_abort | output | 16 | Per-mailbox abort flags |
| mb_event | output | 16 | One-cycle completion/abort event bits |

## Verification
Selection is tried first with one pending mailbox, then with a better priority arriving at a higher index, and then with a tie at that priority against a lower index. These three cases separate a priority compare from a plain index scan, and a lowest-index tie break from a highest-index one. A better mailbox is made pending during an in-flight frame, which exposes a selection that is not frozen. Completion and abort are run on different mailboxes to show which flags each path sets. Ignored writes (an identifier write in transmit mode, a trigger in disabled mode) and a cancel are each observed on the handshake outputs or the ready flags.

// File: rtl/can_txarb_pkg.sv
package can_txarb_pkg;

    localparam int ID_W    = 32;
    localparam int IDENT_W = 29;

    localparam int MODE_LSB   = 24;
    localparam int PRIO_LSB   = 16;
    localparam int DLC_LSB    = 16;
    localparam int RTR_BIT    = 20;
    localparam int CMD_BIT    = 23;
    localparam int EXT_BIT    = 29;
    localparam int STD_LSB    = 18;
    localparam int STD_W      = 11;

    typedef enum logic [2:0] {
        MB_OFF      = 3'd0,
        MB_RX       = 3'd1,
        MB_RX_OVW   = 3'd2,
        MB_TX       = 3'd3,
        MB_CONSUME  = 3'd4,
        MB_PRODUCE  = 3'd5
    } mb_mode_e;

    typedef enum logic [2:0] {
        REG_MODE = 3'd0,
        REG_ID   = 3'd1,
        REG_DLO  = 3'd2,
        REG_DHI  = 3'd3,
        REG_CTRL = 3'd4
    } cfg_reg_e;

    typedef struct packed {
        mb_mode_e    mode;
        logic [3:0]  prio;
        logic [31:0] id;
        logic [31:0] dlo;
        logic [31:0] dhi;
        logic [3:0]  dlc;
        logic        rtr;
        logic        pending;
        logic        ready;
        logic        aborted;
    } mbox_t;

    function automatic logic [IDENT_W-1:0] decode_ident(input logic [ID_W-1:0] id);
        if (id[EXT_BIT])
            return id[IDENT_W-1:0];
        else
            return {{(IDENT_W-STD_W){1'b0}}, id[STD_LSB +: STD_W]};
    endfunction

endpackage

// File: rtl/txarb_mbox_bank.sv
module txarb_mbox_bank
    import can_txarb_pkg::*;
#(
    parameter int NUM_MB = 16,
    localparam int MB_W = $clog2(NUM_MB)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_we,
    input  logic [MB_W-1:0] cfg_mb,
    input  logic [2:0]      cfg_reg,
    input  logic [31:0]     cfg_wdata,
    input  logic            busy,
    input  logic [MB_W-1:0] flight_mb,
    input  logic            finish,
    input  logic            finish_abort,
    output mbox_t           mbs [NUM_MB]
);

    for (genvar g = 0; g < NUM_MB; g++) begin : g_mb
        logic hit;
        logic in_flight;
        mb_mode_e new_mode;

        assign hit       = cfg_we && (cfg_mb == MB_W'(g));
        assign in_flight = busy && (flight_mb == MB_W'(g));
        assign new_mode  = mb_mode_e'(cfg_wdata[MODE_LSB +: 3]);

        always_ff @(posedge clk) begin
            if (rst) begin
                mbs[g] <= '{mode: MB_OFF, prio: '0, id: '0, dlo: '0, dhi: '0,
                            dlc: '0, rtr: 1'b0, pending: 1'b0, ready: 1'b1,
                            aborted: 1'b0};
            end else begin
                if (hit) begin
                    case (cfg_reg_e'(cfg_reg))
                        REG_MODE: begin
                            mbs[g].mode <= new_mode;
                            mbs[g].prio <= cfg_wdata[PRIO_LSB +: 4];
                            if (new_mode != MB_TX && mbs[g].pending && !in_flight) begin
                                mbs[g].pending <= 1'b0;
                                mbs[g].ready   <= 1'b1;
                            end
                        end
                        REG_ID: begin
                            if (mbs[g].mode == MB_OFF)
                                mbs[g].id <= cfg_wdata;
                        end
                        REG_DLO: mbs[g].dlo <= cfg_wdata;
                        REG_DHI: mbs[g].dhi <= cfg_wdata;
                        REG_CTRL: begin
                            if (cfg_wdata[CMD_BIT] && mbs[g].mode == MB_TX && mbs[g].ready) begin
                                mbs[g].pending <= 1'b1;
                                mbs[g].ready   <= 1'b0;
                                mbs[g].aborted <= 1'b0;
                                mbs[g].dlc     <= cfg_wdata[DLC_LSB +: 4];
                                mbs[g].rtr     <= cfg_wdata[RTR_BIT];
                            end
                        end
                        default: ;
                    endcase
                end
                if (finish && in_flight) begin
                    mbs[g].pending <= 1'b0;
                    mbs[g].ready   <= 1'b1;
                    mbs[g].aborted <= finish_abort;
                end
            end
        end
    end

endmodule

// File: rtl/txarb_prio_select.sv
module txarb_prio_select
    import can_txarb_pkg::*;
#(
    parameter int NUM_MB = 16,
    localparam int MB_W = $clog2(NUM_MB)
) (
    input  mbox_t           mbs [NUM_MB],
    output logic            any_elig,
    output logic [MB_W-1:0] win_mb
);

    logic [NUM_MB-1:0] elig;

    for (genvar g = 0; g < NUM_MB; g++) begin : g_elig
        assign elig[g] = mbs[g].pending && (mbs[g].mode == MB_TX);
    end

    always_comb begin
        logic [3:0] best;
        any_elig = 1'b0;
        win_mb   = '0;
        best     = '1;
        for (int i = NUM_MB - 1; i >= 0; i--) begin
            if (elig[i] && (!any_elig || mbs[i].prio <= best)) begin
                any_elig = 1'b1;
                best     = mbs[i].prio;
                win_mb   = MB_W'(i);
            end
        end
    end

endmodule

// File: rtl/txarb_handshake.sv
module txarb_handshake #(
    parameter int NUM_MB = 16,
    localparam int MB_W = $clog2(NUM_MB)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            any_elig,
    input  logic [MB_W-1:0] win_mb,
    input  logic            tx_accept,
    input  logic            tx_done,
    input  logic            tx_abort,
    output logic            busy,
    output logic [MB_W-1:0] cur_mb,
    output logic            tx_req,
    output logic            finish,
    output logic            finish_abort
);

    logic [MB_W-1:0] held_mb;

    assign tx_req       = !busy && any_elig;
    assign cur_mb       = busy ? held_mb : win_mb;
    assign finish       = busy && (tx_done || tx_abort);
    assign finish_abort = busy && tx_abort;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            held_mb <= '0;
        end else if (busy) begin
            if (tx_done || tx_abort)
                busy <= 1'b0;
        end else if (tx_req && tx_accept) begin
            busy    <= 1'b1;
            held_mb <= win_mb;
        end
    end

endmodule

// File: rtl/can_tx_arbiter.sv
module can_tx_arbiter
    import can_txarb_pkg::*;
#(
    parameter int NUM_MB = 16,
    localparam int MB_W = $clog2(NUM_MB)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [MB_W-1:0]   cfg_mb,
    input  logic [2:0]        cfg_reg,
    input  logic [31:0]       cfg_wdata,
    output logic              tx_req,
    input  logic              tx_accept,
    input  logic              tx_done,
    input  logic              tx_abort,
    output logic [MB_W-1:0]   tx_mb,
    output logic              tx_ext,
    output logic [IDENT_W-1:0] tx_ident,
    output logic              tx_rtr,
    output logic [3:0]        tx_dlc,
    output logic [63:0]       tx_data,
    output logic [NUM_MB-1:0] mb_ready,
    output logic [NUM_MB-1:0] mb_abort,
    output logic [NUM_MB-1:0] mb_event
);

    mbox_t           mbs [NUM_MB];
    logic            any_elig;
    logic [MB_W-1:0] win_mb;
    logic            busy;
    logic            finish;
    logic            finish_abort;

    txarb_handshake #(.NUM_MB(NUM_MB)) u_hs (
        .clk(clk), .rst(rst), .any_elig(any_elig), .win_mb(win_mb),
        .tx_accept(tx_accept), .tx_done(tx_done), .tx_abort(tx_abort),
        .busy(busy), .cur_mb(tx_mb), .tx_req(tx_req),
        .finish(finish), .finish_abort(finish_abort)
    );

    txarb_mbox_bank #(.NUM_MB(NUM_MB)) u_bank (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mb(cfg_mb),
        .cfg_reg(cfg_reg), .cfg_wdata(cfg_wdata), .busy(busy),
        .flight_mb(tx_mb), .finish(finish), .finish_abort(finish_abort),
        .mbs(mbs)
    );

    txarb_prio_select #(.NUM_MB(NUM_MB)) u_sel (
        .mbs(mbs), .any_elig(any_elig), .win_mb(win_mb)
    );

    mbox_t cur;
    assign cur      = mbs[tx_mb];
    assign tx_ext   = cur.id[EXT_BIT];
    assign tx_ident = decode_ident(cur.id);
    assign tx_rtr   = cur.rtr;
    assign tx_dlc   = cur.dlc;
    assign tx_data  = {cur.dhi, cur.dlo};

    for (genvar g = 0; g < NUM_MB; g++) begin : g_flags
        assign mb_ready[g] = mbs[g].ready;
        assign mb_abort[g] = mbs[g].aborted;
        always_ff @(posedge clk) begin
            if (rst) mb_event[g] <= 1'b0;
            else     mb_event[g] <= finish && (tx_mb == MB_W'(g));
        end
    end

endmodule

// File: rtl/can_tx_arbiter_chk.sv
module can_tx_arbiter_chk #(
    parameter int NUM_MB = 16,
    localparam int MB_W = $clog2(NUM_MB)
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              tx_req,
    input logic              tx_done,
    input logic              tx_abort,
    input logic [MB_W-1:0]   tx_mb,
    input logic [NUM_MB-1:0] mb_ready,
    input logic [NUM_MB-1:0] mb_abort,
    input logic [NUM_MB-1:0] mb_event
);

    AST_NO_REQ_IN_FLIGHT: assert property (@(posedge clk) disable iff (rst)
        busy |-> !tx_req) else $error("request while in flight"); // R9

    AST_HOLD_SELECTION: assert property (@(posedge clk) disable iff (rst)
        (busy && !tx_done && !tx_abort) |=> (busy && $stable(tx_mb)))
        else $error("selection moved"); // R9

    AST_REQ_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        tx_req |-> !mb_ready[tx_mb]) else $error("offered ready mailbox"); // R2

    AST_EVENT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mb_event)) else $error("several events"); // R10

    AST_EVENT_READY: assert property (@(posedge clk) disable iff (rst)
        (mb_event != '0) |-> ((mb_ready & mb_event) == mb_event))
        else $error("event without ready"); // R10

    AST_ABORT_FLAG: assert property (@(posedge clk) disable iff (rst)
        (busy && tx_abort) |=> ((mb_abort & mb_event) != '0))
        else $error("abort flag missing"); // R11

endmodule

bind can_tx_arbiter can_tx_arbiter_chk #(.NUM_MB(NUM_MB)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .tx_req(tx_req), .tx_done(tx_done),
    .tx_abort(tx_abort), .tx_mb(tx_mb), .mb_ready(mb_ready),
    .mb_abort(mb_abort), .mb_event(mb_event)
);

// File: tb/tb_can_tx_arbiter.sv
module tb_can_tx_arbiter;

    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst = 1;
    logic        cfg_we = 0;
    logic [3:0]  cfg_mb = 0;
    logic [2:0]  cfg_reg = 0;
    logic [31:0] cfg_wdata = 0;
    logic        tx_req, tx_ext, tx_rtr;
    logic        tx_accept = 0, tx_done = 0, tx_abort = 0;
    logic [3:0]  tx_mb, tx_dlc;
    logic [28:0] tx_ident;
    logic [63:0] tx_data;
    logic [15:0] mb_ready, mb_abort, mb_event;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_tx_arbiter dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mb(cfg_mb), .cfg_reg(cfg_reg),
        .cfg_wdata(cfg_wdata), .tx_req(tx_req), .tx_accept(tx_accept),
        .tx_done(tx_done), .tx_abort(tx_abort), .tx_mb(tx_mb), .tx_ext(tx_ext),
        .tx_ident(tx_ident), .tx_rtr(tx_rtr), .tx_dlc(tx_dlc), .tx_data(tx_data),
        .mb_ready(mb_ready), .mb_abort(mb_abort), .mb_event(mb_event)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] mb, input logic [2:0] r, input logic [31:0] d);
        cfg_we = 1; cfg_mb = mb; cfg_reg = r; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    function automatic logic [31:0] mode_word(input logic [2:0] m, input logic [3:0] p);
        return {5'b0, m, 4'b0, p, 16'b0};
    endfunction

    function automatic logic [31:0] ctrl_word(input logic rtr, input logic [3:0] dlc);
        return {8'b0, 1'b1, 2'b0, rtr, dlc, 16'b0};
    endfunction

    task automatic accept_one();
        tx_accept = 1;
        @(negedge clk);
        tx_accept = 0;
    endtask

    task automatic finish_one(input logic abort);
        tx_done = !abort; tx_abort = abort;
        @(negedge clk);
        tx_done = 0; tx_abort = 0;
    endtask

    task automatic t_reset();
        check("R1 ready", mb_ready, 16'hFFFF);
        check("R1 abort", mb_abort, 0);
        check("R1 event", mb_event, 0);
        check("R1 req", tx_req, 0);
    endtask

    task automatic t_ignored_trigger();
        wr(3, 4, ctrl_word(0, 4));
        check("R3 ready", mb_ready[3], 1);
        check("R3 req", tx_req, 0);
    endtask

    task automatic t_single();
        wr(2, 1, 32'h123 << 18);
        wr(2, 2, 32'hCAFE_0001);
        wr(2, 3, 32'hBEEF_0002);
        wr(2, 0, mode_word(3, 5));
        wr(2, 4, ctrl_word(1, 8));
        check("R2 req", tx_req, 1);
        check("R2 ready", mb_ready[2], 0);
        check("R2 dlc", tx_dlc, 8);
        check("R2 rtr", tx_rtr, 1);
        check("R7 ext", tx_ext, 0);
        check("R7 ident", tx_ident, 29'h123);
        check("R12 data", tx_data, 64'hBEEF_0002_CAFE_0001);
        wr(2, 1, 32'h2000_0ABC);
        check("R6 ident kept", tx_ident, 29'h123);
        check("R6 ext kept", tx_ext, 0);
    endtask

    task automatic t_priority_tie();
        wr(5, 0, mode_word(3, 2));
        wr(5, 4, ctrl_word(0, 1));
        check("R4 mb", tx_mb, 5);
        wr(4, 1, 32'h2000_1234);
        wr(4, 0, mode_word(3, 2));
        wr(4, 4, ctrl_word(0, 3));
        check("R5 mb", tx_mb, 4);
        check("R7 ext", tx_ext, 1);
        check("R7 ident ext", tx_ident, 29'h1234);
    endtask

    task automatic t_hold_complete();
        accept_one();
        check("R9 req low", tx_req, 0);
        wr(1, 0, mode_word(3, 0));
        wr(1, 4, ctrl_word(0, 2));
        check("R9 held mb", tx_mb, 4);
        check("R9 req still low", tx_req, 0);
        finish_one(0);
        check("R10 event", mb_event, 16'h0010);
        check("R10 ready", mb_ready[4], 1);
        check("R10 abort", mb_abort[4], 0);
        @(negedge clk);
        check("R10 pulse end", mb_event, 0);
    endtask

    task automatic t_abort();
        check("R4 best prio", tx_mb, 1);
        accept_one();
        finish_one(1);
        check("R11 event", mb_event, 16'h0002);
        check("R11 ready", mb_ready[1], 1);
        check("R11 abort", mb_abort[1], 1);
        wr(1, 4, ctrl_word(0, 2));
        check("R11 abort cleared", mb_abort[1], 0);
        wr(1, 0, mode_word(0, 0));
        check("R8 cancel ready 1", mb_ready[1], 1);
    endtask

    task automatic t_cancel();
        check("R4 next", tx_mb, 5);
        wr(5, 0, mode_word(0, 2));
        check("R8 ready", mb_ready[5], 1);
        check("R8 next winner", tx_mb, 2);
        check("R8 req", tx_req, 1);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst = 0;
                @(negedge clk);
                t_reset();
                t_ignored_trigger();
                t_single();
                t_priority_tie();
                t_hold_complete();
                t_abort();
                t_cancel();
            end
            begin
                repeat (5000) @(negedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual timeout expected finish");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule